// File: doc/BRIEF.md
# Set-Associative Tag Directory

This block keeps the bookkeeping for an N-way set-associative cache. It stores no data. Each way of each set holds a record with four parts: a used flag, the full line address, a two-bit permission and an optional lock owner. A controller sends one command at a time. Each command performs a lookup in the set chosen by the line address, may update that set, and returns a registered reply. The reply holds hit, grant, a way number and a victim line address. Each set has a binary-tree pseudo-LRU. It steers victim selection when a set has no room.

The command codes on `cmd_op` are:

| Code | Command |
|------|---------|
| 0 | access check |
| 1 | presence test |
| 2 | room test |
| 3 | allocate |
| 4 | deallocate |
| 5 | victim probe |
| 6 | make-most-recent |
| 7 | set permission |
| 8 | take lock |
| 9 | release lock |
| 10 | test lock |

The codes 11 to 15 do nothing and pulse no event.

The control path is a two-state machine:
- ST_READY raises `cmd_ready`. A valid command is taken there, and the machine moves to ST_REPLY.
- ST_REPLY shows the reply with `rsp_valid` for exactly one cycle, then always returns to ST_READY.

Four single-cycle event outputs report, alongside each reply, whether the tag array was read or written and whether the data array would be read or written.

Top module: `tagdir`

## Requirements
- R1: In ST_READY, `cmd_ready` is 1. A command accepted there makes `rsp_valid` 1 in the next cycle only, and `cmd_ready` is 0 in that cycle. Commands use codes 0 to 10 as listed above, and `rsp_way` is the matching way on a hit and 0 on a miss, except where allocate or probe return their own way. `rsp_addr` is 0 except on a granted probe.
- R2: There are CACHE_BYTES/WAYS/LINE_BYTES sets. The set index is `cmd_addr[IDX_LSB +: log2(sets)]` (bits 7:6 by default). Lines with different index bits never see each other's records.
- R3: Permission codes are 0 absent, 1 invalid, 2 read-only and 3 read-write. A line matches only when it is used, holds a permission other than absent, and has a stored address equal to `cmd_addr`. Presence test returns hit = grant = match.
- R4: Access check grants a match with permission 3. It grants a match with permission 2 only for kind 0 (load) or kind 1 (fetch). It denies kind 2 (store) on a read-only line and denies every kind on an invalid line. Misses are denied.
- R5: A hit from access check, whether granted or denied, makes the matched way most recent. So do make-most-recent and a granted allocate. The tree sends the victim walk toward the side not most recently used. Each node bit of 0 means the victim walk goes to the lower half.
- R6: Room test grants when the line already matches, or when any way of its set is unused or absent.
- R7: Allocate is refused when the line already matches or when the set has no room. Otherwise it fills the lowest-numbered unused or absent way and returns that way. The new line has permission invalid and no lock owner.
- R8: Victim probe grants only when the set has no room. It then returns the way chosen by the tree and the full line address stored there. Otherwise it returns grant 0 and address 0.
- R9: Set permission writes `cmd_perm` into a matching line and grants. On a miss it changes nothing.
- R10: Take lock stores `cmd_ctx` as the owner of a matching line, and release lock clears the owner. Test lock grants only when the line matches and its stored owner equals `cmd_ctx`.
- R11: Deallocate frees a matching line. The line stops matching, and its way is again the lowest free candidate for allocate.
- R12: Events arrive with the reply, in order {`ev_tag_rd`, `ev_tag_wr`, `ev_data_rd`, `ev_data_wr`}.
  - Every defined command pulses tag read.
  - A granted allocate, deallocate, set permission, take lock or release lock pulses tag write.
  - A granted access pulses data read for kinds 0 and 1, and data write otherwise.
- R13: After reset, every way is unused, every lock is released, every tree points at way 0, `cmd_ready` is 1, and `rsp_valid` and all event outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command taken this cycle if valid |
| cmd_op | input | 4 | Command code |
| cmd_addr | input | ADDR_W | Line-aligned address |
| cmd_kind | input | 2 | Request kind for access check |
| cmd_perm | input | 2 | Permission for set permission |
| cmd_ctx | input | CTX_W | Context ID for lock commands |
| rsp_valid | output | 1 | Reply valid |
| rsp_hit | output | 1 | Line matched |
| rsp_grant | output | 1 | Command granted |
| rsp_way | output | WAY_W | Way number |
| rsp_addr | output | ADDR_W | Victim line address |
| ev_tag_rd | output | 1 | Tag array read event |
| ev_tag_wr | output | 1 | Tag array write event |
| ev_data_rd | output | 1 | Data array read event |
| ev_data_wr | output | 1 | Data array write event |

## Verification
The scripted sequence fills one set way by way, then uses all three request kinds on lines in each permission state. This separates the read-only gating from plain hit detection. Probes run after different touch orders, so a tree that ignored denied hits or took the wrong branch would name a different victim. Deallocation, the absent permission and re-allocation check that the lowest free way is picked and that locks do not survive reuse. A line in another set with the same upper bits checks set isolation. A mid-run reset followed by presence and probe commands checks the cleared state.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

    typedef enum logic [3:0] {
        OP_ACCESS   = 4'd0,
        OP_PRESENT  = 4'd1,
        OP_AVAIL    = 4'd2,
        OP_ALLOC    = 4'd3,
        OP_FREE     = 4'd4,
        OP_PROBE    = 4'd5,
        OP_TOUCH    = 4'd6,
        OP_SETPERM  = 4'd7,
        OP_LOCK     = 4'd8,
        OP_UNLOCK   = 4'd9,
        OP_LOCKTEST = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        PERM_ABSENT  = 2'd0,
        PERM_INVALID = 2'd1,
        PERM_RDONLY  = 2'd2,
        PERM_RDWR    = 2'd3
    } perm_e;

    typedef enum logic [1:0] {
        REQ_LOAD  = 2'd0,
        REQ_FETCH = 2'd1,
        REQ_STORE = 2'd2,
        REQ_RSVD  = 2'd3
    } req_e;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_REPLY = 1'b1
    } fsm_e;

endpackage

// File: rtl/tagdir_match.sv
module tagdir_match
    import tagdir_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int WAY_W  = 2,
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] probe_addr,
    input  logic [ADDR_W-1:0] way_tag  [WAYS],
    input  perm_e             way_perm [WAYS],
    input  logic [WAYS-1:0]   way_used,
    output logic [WAYS-1:0]   hit_vec,
    output logic              any_hit,
    output logic              any_free,
    output logic [WAY_W-1:0]  hit_way,
    output logic [WAY_W-1:0]  free_way
);

    logic [WAYS-1:0] free_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_vec[w]  = way_used[w] && (way_perm[w] != PERM_ABSENT)
                             && (way_tag[w] == probe_addr);
        assign free_vec[w] = !way_used[w] || (way_perm[w] == PERM_ABSENT);
    end

    assign any_hit  = |hit_vec;
    assign any_free = |free_vec;

    // lowest-numbered way wins in both encoders
    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w])  hit_way  = WAY_W'(w);
            if (free_vec[w]) free_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/tagdir_plru.sv
module tagdir_plru #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int SET_W = 2,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] look_set,
    output logic [WAY_W-1:0] victim_way
);

    localparam int NODES = WAYS - 1;
    localparam int LVL   = $clog2(WAYS);

    logic [NODES-1:0] tree [SETS];

    function automatic logic [WAY_W-1:0] walk(input logic [NODES-1:0] t);
        int n;
        logic [WAY_W-1:0] w;
        n = 0;
        w = '0;
        for (int l = 0; l < LVL; l++) begin
            w = (w << 1) | WAY_W'(t[n]);
            n = 2 * n + 1 + int'(t[n]);
        end
        return w;
    endfunction

    function automatic logic [NODES-1:0] mark(input logic [NODES-1:0] t,
                                              input logic [WAY_W-1:0] way);
        int n;
        logic b;
        logic [NODES-1:0] r;
        r = t;
        n = 0;
        for (int l = 0; l < LVL; l++) begin
            b    = way[LVL-1-l];
            r[n] = ~b;
            n    = 2 * n + 1 + int'(b);
        end
        return r;
    endfunction

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic [NODES-1:0] bits_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits_q <= '0;
            else if (touch_en && (touch_set == SET_W'(s)))
                bits_q <= mark(bits_q, touch_way);
        end
        assign tree[s] = bits_q;
    end

    assign victim_way = walk(tree[look_set]);

    // checker: right after a touch the touched way is never the victim
    logic             chk_vld;
    logic [SET_W-1:0] chk_set;
    logic [WAY_W-1:0] chk_way;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_vld <= 1'b0;
            chk_set <= '0;
            chk_way <= '0;
        end else begin
            chk_vld <= touch_en;
            chk_set <= touch_set;
            chk_way <= touch_way;
        end
    end

    AST_TOUCH_MOVES_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        chk_vld |-> (walk(tree[chk_set]) != chk_way)); // R5

endmodule

// File: rtl/tagdir.sv
module tagdir
    import tagdir_pkg::*;
#(
    parameter int CACHE_BYTES = 1024,
    parameter int LINE_BYTES  = 64,
    parameter int WAYS        = 4,
    parameter int ADDR_W      = 16,
    parameter int IDX_LSB     = 6,
    parameter int CTX_W       = 4,
    parameter int WAY_W       = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_kind,
    input  logic [1:0]        cmd_perm,
    input  logic [CTX_W-1:0]  cmd_ctx,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_grant,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              ev_tag_rd,
    output logic              ev_tag_wr,
    output logic              ev_data_rd,
    output logic              ev_data_wr
);

    localparam int SETS  = CACHE_BYTES / WAYS / LINE_BYTES;
    localparam int SET_W = $clog2(SETS);

    // ---------------- record storage ----------------
    logic [ADDR_W-1:0] tag_q  [SETS][WAYS];
    perm_e             perm_q [SETS][WAYS];
    logic [CTX_W-1:0]  own_q  [SETS][WAYS];
    logic [WAYS-1:0]   used_q [SETS];
    logic [WAYS-1:0]   ownv_q [SETS];

    fsm_e state_q, state_d;
    logic accept;

    logic [SET_W-1:0]  set_idx;
    logic [ADDR_W-1:0] row_tag  [WAYS];
    perm_e             row_perm [WAYS];
    logic [WAYS-1:0]   row_used;

    assign set_idx  = cmd_addr[IDX_LSB +: SET_W];
    assign row_used = used_q[set_idx];

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            row_tag[w]  = tag_q[set_idx][w];
            row_perm[w] = perm_q[set_idx][w];
        end
    end

    // ---------------- lookup and replacement ----------------
    logic [WAYS-1:0]  hit_vec;
    logic             any_hit, any_free;
    logic [WAY_W-1:0] hit_way, free_way, victim_way;
    logic             touch_c;
    logic [WAY_W-1:0] touch_way_c;

    tagdir_match #(
        .WAYS   (WAYS),
        .WAY_W  (WAY_W),
        .ADDR_W (ADDR_W)
    ) u_match (
        .probe_addr (cmd_addr),
        .way_tag    (row_tag),
        .way_perm   (row_perm),
        .way_used   (row_used),
        .hit_vec    (hit_vec),
        .any_hit    (any_hit),
        .any_free   (any_free),
        .hit_way    (hit_way),
        .free_way   (free_way)
    );

    tagdir_plru #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .SET_W (SET_W),
        .WAY_W (WAY_W)
    ) u_plru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (accept && touch_c),
        .touch_set  (set_idx),
        .touch_way  (touch_way_c),
        .look_set   (set_idx),
        .victim_way (victim_way)
    );

    // ---------------- command decode ----------------
    op_e  op;
    logic is_read;
    logic d_hit, d_grant, d_tr, d_tw, d_dr, d_dw;
    logic [WAY_W-1:0]  d_way;
    logic [ADDR_W-1:0] d_addr;
    logic wr_new, wr_drop, wr_perm, wr_own, wr_unown;

    assign op      = op_e'(cmd_op);
    assign is_read = (req_e'(cmd_kind) == REQ_LOAD) || (req_e'(cmd_kind) == REQ_FETCH);

    always_comb begin
        d_hit       = any_hit;
        d_grant     = 1'b0;
        d_way       = any_hit ? hit_way : '0;
        d_addr      = '0;
        d_tr        = 1'b1;
        d_tw        = 1'b0;
        d_dr        = 1'b0;
        d_dw        = 1'b0;
        touch_c     = 1'b0;
        touch_way_c = hit_way;
        wr_new      = 1'b0;
        wr_drop     = 1'b0;
        wr_perm     = 1'b0;
        wr_own      = 1'b0;
        wr_unown    = 1'b0;
        unique case (op)
            OP_ACCESS: begin
                if (any_hit) begin
                    touch_c = 1'b1;
                    if (row_perm[hit_way] == PERM_RDWR)
                        d_grant = 1'b1;
                    else if (row_perm[hit_way] == PERM_RDONLY)
                        d_grant = is_read;
                end
                d_dr = d_grant && is_read;
                d_dw = d_grant && !is_read;
            end
            OP_PRESENT: d_grant = any_hit;
            OP_AVAIL:   d_grant = any_hit || any_free;
            OP_ALLOC: begin
                if (!any_hit && any_free) begin
                    d_grant     = 1'b1;
                    d_way       = free_way;
                    d_tw        = 1'b1;
                    wr_new      = 1'b1;
                    touch_c     = 1'b1;
                    touch_way_c = free_way;
                end
            end
            OP_FREE: begin
                d_grant = any_hit;
                d_tw    = any_hit;
                wr_drop = any_hit;
            end
            OP_PROBE: begin
                if (!any_hit && !any_free) begin
                    d_grant = 1'b1;
                    d_way   = victim_way;
                    d_addr  = tag_q[set_idx][victim_way];
                end
            end
            OP_TOUCH: begin
                d_grant = any_hit;
                touch_c = any_hit;
            end
            OP_SETPERM: begin
                d_grant = any_hit;
                d_tw    = any_hit;
                wr_perm = any_hit;
            end
            OP_LOCK: begin
                d_grant = any_hit;
                d_tw    = any_hit;
                wr_own  = any_hit;
            end
            OP_UNLOCK: begin
                d_grant  = any_hit;
                d_tw     = any_hit;
                wr_unown = any_hit;
            end
            OP_LOCKTEST: begin
                d_grant = any_hit && ownv_q[set_idx][hit_way]
                          && (own_q[set_idx][hit_way] == cmd_ctx);
            end
            default: begin
                d_hit = 1'b0;
                d_way = '0;
                d_tr  = 1'b0;
            end
        endcase
    end

    // ---------------- record updates ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                used_q[s] <= '0;
                ownv_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]  <= '0;
                    perm_q[s][w] <= PERM_ABSENT;
                    own_q[s][w]  <= '0;
                end
            end
        end else if (accept) begin
            if (wr_new) begin
                tag_q[set_idx][free_way]  <= cmd_addr;
                perm_q[set_idx][free_way] <= PERM_INVALID;
                used_q[set_idx][free_way] <= 1'b1;
                ownv_q[set_idx][free_way] <= 1'b0;
            end
            if (wr_drop) begin
                used_q[set_idx][hit_way] <= 1'b0;
                ownv_q[set_idx][hit_way] <= 1'b0;
            end
            if (wr_perm)
                perm_q[set_idx][hit_way] <= perm_e'(cmd_perm);
            if (wr_own) begin
                ownv_q[set_idx][hit_way] <= 1'b1;
                own_q[set_idx][hit_way]  <= cmd_ctx;
            end
            if (wr_unown)
                ownv_q[set_idx][hit_way] <= 1'b0;
        end
    end

    // ---------------- control state machine ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (cmd_valid) state_d = ST_REPLY;
            ST_REPLY: state_d = ST_READY;
            default:  state_d = ST_READY;
        endcase
    end

    always_comb begin
        cmd_ready = (state_q == ST_READY);
        rsp_valid = (state_q == ST_REPLY);
    end

    assign accept = cmd_valid && (state_q == ST_READY);

    // ---------------- reply registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit    <= 1'b0;
            rsp_grant  <= 1'b0;
            rsp_way    <= '0;
            rsp_addr   <= '0;
            ev_tag_rd  <= 1'b0;
            ev_tag_wr  <= 1'b0;
            ev_data_rd <= 1'b0;
            ev_data_wr <= 1'b0;
        end else if (accept) begin
            rsp_hit    <= d_hit;
            rsp_grant  <= d_grant;
            rsp_way    <= d_way;
            rsp_addr   <= d_addr;
            ev_tag_rd  <= d_tr;
            ev_tag_wr  <= d_tw;
            ev_data_rd <= d_dr;
            ev_data_wr <= d_dw;
        end else begin
            ev_tag_rd  <= 1'b0;
            ev_tag_wr  <= 1'b0;
            ev_data_rd <= 1'b0;
            ev_data_wr <= 1'b0;
        end
    end

    // ---------------- assertions ----------------
    AST_REPLY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> rsp_valid); // R1
    AST_REPLY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R1
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready); // R1
    AST_DATA_EV_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_data_rd || ev_data_wr) |-> (rsp_valid && rsp_hit && rsp_grant)); // R4
    AST_DATA_EV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_data_rd && ev_data_wr)); // R12
    AST_EV_WITH_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tag_rd || ev_tag_wr) |-> rsp_valid); // R12
    AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R7

endmodule

// File: tb/tagdir_bench.sv
module tagdir_bench;

    localparam int ADDR_W = 16;
    localparam int WAY_W  = 2;
    localparam int CTX_W  = 4;
    localparam int NV     = 49;

    localparam logic [3:0] ACC = 4'd0, PRS = 4'd1, AVL = 4'd2, ALC = 4'd3, DEA = 4'd4,
                           PRB = 4'd5, TCH = 4'd6, SPM = 4'd7, LKS = 4'd8, LKC = 4'd9,
                           LKT = 4'd10;
    localparam logic [1:0] KL = 2'd0, KI = 2'd1, KS = 2'd2;
    localparam logic [1:0] P0 = 2'd0, P2 = 2'd2, P3 = 2'd3;
    localparam logic [3:0] C0 = 4'd0, C3 = 4'd3, C5 = 4'd5, C9 = 4'd9;

    // {op, addr, kind, perm, ctx, hit, grant, way, vaddr, events, req}
    localparam logic [59:0] VEC [NV] = '{
        {ACC, 16'h0140, KL, P0, C0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h8, 8'd4},  // R4 miss
        {AVL, 16'h0140, KL, P0, C0, 1'b0, 1'b1, 2'd0, 16'h0000, 4'h8, 8'd6},  // R6
        {ALC, 16'h0140, KL, P0, C0, 1'b0, 1'b1, 2'd0, 16'h0000, 4'hC, 8'd7},  // R7
        {ALC, 16'h0240, KL, P0, C0, 1'b0, 1'b1, 2'd1, 16'h0000, 4'hC, 8'd7},
        {ALC, 16'h0340, KL, P0, C0, 1'b0, 1'b1, 2'd2, 16'h0000, 4'hC, 8'd7},
        {ALC, 16'h0440, KL, P0, C0, 1'b0, 1'b1, 2'd3, 16'h0000, 4'hC, 8'd7},
        {ACC, 16'h0140, KL, P0, C0, 1'b1, 1'b0, 2'd0, 16'h0000, 4'h8, 8'd4},  // R4 invalid
        {AVL, 16'h0540, KL, P0, C0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h8, 8'd6},  // R6 full
        {PRB, 16'h0540, KL, P0, C0, 1'b0, 1'b1, 2'd2, 16'h0340, 4'h8, 8'd8},  // R8
        {SPM, 16'h0240, KL, P2, C0, 1'b1, 1'b1, 2'd1, 16'h0000, 4'hC, 8'd9},  // R9
        {ACC, 16'h0240, KS, P0, C0, 1'b1, 1'b0, 2'd1, 16'h0000, 4'h8, 8'd4},  // R4 store RO
        {ACC, 16'h0240, KI, P0, C0, 1'b1, 1'b1, 2'd1, 16'h0000, 4'hA, 8'd4},
        {ACC, 16'h0240, KL, P0, C0, 1'b1, 1'b1, 2'd1, 16'h0000, 4'hA, 8'd4},
        {SPM, 16'h0340, KL, P3, C0, 1'b1, 1'b1, 2'd2, 16'h0000, 4'hC, 8'd9},
        {ACC, 16'h0340, KS, P0, C0, 1'b1, 1'b1, 2'd2, 16'h0000, 4'h9, 8'd4},  // R4 store RW
        {PRB, 16'h0540, KL, P0, C0, 1'b0, 1'b1, 2'd0, 16'h0140, 4'h8, 8'd5},  // R5
        {TCH, 16'h0140, KL, P0, C0, 1'b1, 1'b1, 2'd0, 16'h0000, 4'h8, 8'd5},
        {PRB, 16'h0540, KL, P0, C0, 1'b0, 1'b1, 2'd3, 16'h0440, 4'h8, 8'd5},
        {ALC, 16'h0540, KL, P0, C0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h8, 8'd7},  // R7 full
        {ALC, 16'h0240, KL, P0, C0, 1'b1, 1'b0, 2'd1, 16'h0000, 4'h8, 8'd7},  // R7 present
        {DEA, 16'h0340, KL, P0, C0, 1'b1, 1'b1, 2'd2, 16'h0000, 4'hC, 8'd11}, // R11
        {PRS, 16'h0340, KL, P0, C0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h8, 8'd11},
        {AVL, 16'h0540, KL, P0, C0, 1'b0, 1'b1, 2'd0, 16'h0000, 4'h8, 8'd6},
        {ALC, 16'h0540, KL, P0, C0, 1'b0, 1'b1, 2'd2, 16'h0000, 4'hC, 8'd11},
        {SPM, 16'h0140, KL, P0, C0, 1'b1, 1'b1, 2'd0, 16'h0000, 4'hC, 8'd9},
        {PRS, 16'h0140, KL, P0, C0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h8, 8'd3},  // R3 absent
        {ACC, 16'h0140, KL, P0, C0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h8, 8'd3},
        {AVL, 16'h0140, KL, P0, C0, 1'b0, 1'b1, 2'd0, 16'h0000, 4'h8, 8'd6},
        {ALC, 16'h0640, KL, P0, C0, 1'b0, 1'b1, 2'd0, 16'h0000, 4'hC, 8'd7},
        {LKT, 16'h0640, KL, P0, C5, 1'b1, 1'b0, 2'd0, 16'h0000, 4'h8, 8'd10}, // R10
        {LKS, 16'h0640, KL, P0, C5, 1'b1, 1'b1, 2'd0, 16'h0000, 4'hC, 8'd10},
        {LKT, 16'h0640, KL, P0, C5, 1'b1, 1'b1, 2'd0, 16'h0000, 4'h8, 8'd10},
        {LKT, 16'h0640, KL, P0, C3, 1'b1, 1'b0, 2'd0, 16'h0000, 4'h8, 8'd10},
        {LKC, 16'h0640, KL, P0, C0, 1'b1, 1'b1, 2'd0, 16'h0000, 4'hC, 8'd10},
        {LKT, 16'h0640, KL, P0, C5, 1'b1, 1'b0, 2'd0, 16'h0000, 4'h8, 8'd10},
        {LKS, 16'h0740, KL, P0, C5, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h8, 8'd10},
        {LKS, 16'h0240, KL, P0, C9, 1'b1, 1'b1, 2'd1, 16'h0000, 4'hC, 8'd10},
        {DEA, 16'h0240, KL, P0, C0, 1'b1, 1'b1, 2'd1, 16'h0000, 4'hC, 8'd11},
        {ALC, 16'h0240, KL, P0, C0, 1'b0, 1'b1, 2'd1, 16'h0000, 4'hC, 8'd7},
        {LKT, 16'h0240, KL, P0, C9, 1'b1, 1'b0, 2'd1, 16'h0000, 4'h8, 8'd7},  // R7 lock cleared
        {PRS, 16'h0100, KL, P0, C0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h8, 8'd2},  // R2
        {ALC, 16'h0100, KL, P0, C0, 1'b0, 1'b1, 2'd0, 16'h0000, 4'hC, 8'd2},
        {PRS, 16'h0100, KL, P0, C0, 1'b1, 1'b1, 2'd0, 16'h0000, 4'h8, 8'd2},
        {PRS, 16'h0180, KL, P0, C0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h8, 8'd2},
        {PRS, 16'h0440, KL, P0, C0, 1'b1, 1'b1, 2'd3, 16'h0000, 4'h8, 8'd3},
        {PRB, 16'h0740, KL, P0, C0, 1'b0, 1'b1, 2'd3, 16'h0440, 4'h8, 8'd8},
        {ACC, 16'h0440, KL, P0, C0, 1'b1, 1'b0, 2'd3, 16'h0000, 4'h8, 8'd4},
        {PRB, 16'h0740, KL, P0, C0, 1'b0, 1'b1, 2'd0, 16'h0640, 4'h8, 8'd5},
        {PRB, 16'h0180, KL, P0, C0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h8, 8'd8}   // R8 room left
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [3:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [1:0]        cmd_kind = '0;
    logic [1:0]        cmd_perm = '0;
    logic [CTX_W-1:0]  cmd_ctx = '0;
    logic              rsp_valid, rsp_hit, rsp_grant;
    logic [WAY_W-1:0]  rsp_way;
    logic [ADDR_W-1:0] rsp_addr;
    logic              ev_tag_rd, ev_tag_wr, ev_data_rd, ev_data_wr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tagdir u_tagdir (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .cmd_kind   (cmd_kind),
        .cmd_perm   (cmd_perm),
        .cmd_ctx    (cmd_ctx),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_grant  (rsp_grant),
        .rsp_way    (rsp_way),
        .rsp_addr   (rsp_addr),
        .ev_tag_rd  (ev_tag_rd),
        .ev_tag_wr  (ev_tag_wr),
        .ev_data_rd (ev_data_rd),
        .ev_data_wr (ev_data_wr)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // drive one command; returns with the reply visible (sampled at negedge)
    task automatic issue(input logic [3:0] op, input logic [15:0] addr, input logic [1:0] kind,
                         input logic [1:0] perm, input logic [3:0] ctx);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = addr;
        cmd_kind  = kind;
        cmd_perm  = perm;
        cmd_ctx   = ctx;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle_after();
        @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R13: state after reset
        check("R13 cmd_ready after reset", 32'(cmd_ready), 32'd1);
        check("R13 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R13 events after reset",
              32'({ev_tag_rd, ev_tag_wr, ev_data_rd, ev_data_wr}), 32'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [59:0] v;
            int rq;
            v  = VEC[i];
            rq = int'(v[7:0]);
            issue(v[59:56], v[55:40], v[39:38], v[37:36], v[35:32]);
            check($sformatf("row %0d R%0d hit", i, rq),   32'(rsp_hit),   32'(v[31]));
            check($sformatf("row %0d R%0d grant", i, rq), 32'(rsp_grant), 32'(v[30]));
            check($sformatf("row %0d R%0d way", i, rq),   32'(rsp_way),   32'(v[29:28]));
            check($sformatf("row %0d R%0d addr", i, rq),  32'(rsp_addr),  32'(v[27:12]));
            check($sformatf("row %0d R12 events", i),
                  32'({ev_tag_rd, ev_tag_wr, ev_data_rd, ev_data_wr}), 32'(v[11:8]));
            idle_after();
        end

        // R1: handshake timing around one command
        issue(PRS, 16'h0440, KL, P0, C0);
        check("R1 rsp_valid in reply cycle", 32'(rsp_valid), 32'd1);
        check("R1 cmd_ready low in reply cycle", 32'(cmd_ready), 32'd0);
        @(negedge clk);
        check("R1 rsp_valid drops after one cycle", 32'(rsp_valid), 32'd0);
        check("R1 cmd_ready back", 32'(cmd_ready), 32'd1);
        check("R12 events clear after reply",
              32'({ev_tag_rd, ev_tag_wr, ev_data_rd, ev_data_wr}), 32'd0);

        // R1: undefined code does nothing
        issue(4'd13, 16'h0440, KL, P0, C0);
        check("R1 undefined code hit", 32'(rsp_hit), 32'd0);
        check("R12 undefined code events",
              32'({ev_tag_rd, ev_tag_wr, ev_data_rd, ev_data_wr}), 32'd0);
        idle_after();

        // R13: reset in the middle of a run clears the directory
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R13 cmd_ready after mid reset", 32'(cmd_ready), 32'd1);
        check("R13 rsp_valid after mid reset", 32'(rsp_valid), 32'd0);
        issue(PRS, 16'h0440, KL, P0, C0);
        check("R13 line gone after reset", 32'(rsp_hit), 32'd0);
        idle_after();
        issue(PRB, 16'h0740, KL, P0, C0);
        check("R13 probe denied on empty set", 32'(rsp_grant), 32'd0);
        idle_after();
        issue(ALC, 16'h0440, KL, P0, C0);
        check("R13 alloc lands in way 0", 32'(rsp_way), 32'd0);
        idle_after();
        issue(LKT, 16'h0440, KL, P0, C5);
        check("R13 no owner after reset", 32'(rsp_grant), 32'd0);
        idle_after();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule